// File: doc/BRIEF.md
# Write-Progress Status Read Path

This block forms the byte that a parallel nonvolatile memory puts on its 8-bit data bus for each read strobe. It sits beside the write controller and the storage array. The controller supplies a busy level and a one-cycle pulse marking the start of a program cycle. The write path supplies the byte being programmed, and the array supplies its read data.

While a program cycle runs, the block returns status instead of stored data. The polled bit carries the inverse of the matching bit of the byte being programmed. The toggle bit changes value from one read access to the next. Once the program cycle is over, reads return the array data unchanged. The output-enable of the bus follows the chip-select, output-select and write-select inputs.

All inputs are synchronous to `clk_i`. A read access is the span of cycles in which the read condition holds. Its end is seen at the first clock edge after the condition drops.

Top module: `poll_status_rd`

## Requirements
- R1: `bus_oe_o` is 1 exactly when `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, in the same cycle. While `bus_oe_o` is 0, `bus_o` is all zeros.
- R2: During a read with `busy_i`=0, `bus_o` equals `arr_data_i` in the same cycle.
- R3: During a read with `busy_i`=1, `bus_o[7]` is the complement of `wr_data_i[7]` as sampled in the last cycle in which `prog_start_i` was 1.
- R4: During a read with `busy_i`=1, `bus_o[6]` holds steady for the whole access. Two successive read accesses within one program cycle return opposite values of bit 6. The value of bit 6 on the first such read is not defined.
- R5: During a read with `busy_i`=1, `bus_o[5:0]` is 0.
- R6: When `prog_start_i` is 0, changes on `wr_data_i` have no effect on `bus_o`.
- R7: In a cycle where `prog_start_i` is 1 and a read is active with `busy_i`=1, `bus_o[7]` already shows the complement of that cycle's `wr_data_i[7]`.
- R8: A cycle in which `ce_ni` and `oe_ni` are both low but `we_ni` is low is not a read access. It does not advance the toggle bit.
- R9: After reset, `bus_oe_o` is 0 and `bus_o` is 0 while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output select, active low |
| we_ni | input | 1 | Write select, active low |
| busy_i | input | 1 | Program cycle in progress |
| prog_start_i | input | 1 | One-cycle pulse at program cycle start |
| wr_data_i | input | 8 | Byte from the write path |
| arr_data_i | input | 8 | Array read data |
| bus_o | output | 8 | Data driven toward the bus |
| bus_oe_o | output | 1 | Bus output enable (0 means high impedance) |

## Verification
A program cycle can start while a read access is already in progress. In that cycle, capturing the new byte and forming the polled bit happen together. The bench raises `prog_start_i` and `busy_i` in the middle of an active read, with a new byte whose top bit is the opposite of the previously captured one. It then checks that bit 7 flips in that very cycle and keeps its value once the pulse is gone and `wr_data_i` has moved on. The bench also lets a read access end in the cycle where the toggle would advance, then confirms that the following access shows the opposite bit 6.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;

  function automatic rd_src_e pick_src(input logic rd_act, input logic busy);
    if (!rd_act)   return SRC_NONE;
    else if (busy) return SRC_STATUS;
    else           return SRC_ARRAY;
  endfunction
endpackage

// File: rtl/rd_strobe_det.sv
module rd_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic rd_act_o,
  output logic rd_end_o
);
  logic rd_act_q;

  assign rd_act_o = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_act_q <= 1'b0;
    else         rd_act_q <= rd_act_o;
  end

  // access ends when the read condition drops
  assign rd_end_o = rd_act_q & ~rd_act_o;
endmodule

// File: rtl/tog_unit.sv
module tog_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_end_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tog_q <= 1'b0;
    else if (busy_i && rd_end_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/last_poll_reg.sv
module last_poll_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic eff_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= 1'b0;
    else if (load_i) q <= d_i;
  end

  // bypass so a read coinciding with the start sees the new byte
  assign eff_o = load_i ? d_i : q;
endmodule

// File: rtl/rd_data_fmt.sv
module rd_data_fmt
  import poll_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  rd_src_e           src_i,
  input  logic              last_poll_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stat;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stat
    if (i == POLL_BIT) begin : g_poll
      assign stat[i] = ~last_poll_i;
    end else if (i == TOG_BIT) begin : g_tog
      assign stat[i] = tog_i;
    end else begin : g_zero
      assign stat[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (src_i)
      SRC_ARRAY:  data_o = arr_i;
      SRC_STATUS: data_o = stat;
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/poll_status_rd.sv
module poll_status_rd
  import poll_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              busy_i,
  input  logic              prog_start_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  logic    rd_act, rd_end, tog, last_poll;
  rd_src_e src;

  rd_strobe_det u_det (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .rd_act_o(rd_act), .rd_end_o(rd_end)
  );

  tog_unit u_tog (
    .clk_i, .rst_ni, .busy_i, .rd_end_i(rd_end), .tog_o(tog)
  );

  last_poll_reg u_last (
    .clk_i, .rst_ni, .load_i(prog_start_i),
    .d_i(wr_data_i[POLL_BIT]), .eff_o(last_poll)
  );

  assign src = pick_src(rd_act, busy_i);

  rd_data_fmt #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_fmt (
    .src_i(src), .last_poll_i(last_poll), .tog_i(tog),
    .arr_i(arr_data_i), .data_o(bus_o)
  );

  assign bus_oe_o = rd_act;
endmodule

// File: rtl/poll_status_rd_chk.sv
module poll_status_rd_chk #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              busy_i,
  input logic              prog_start_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o
);
  logic ref_poll, seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_poll <= 1'b0;
      seen     <= 1'b0;
    end else if (prog_start_i) begin
      ref_poll <= wr_data_i[POLL_BIT];
      seen     <= 1'b1;
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0);
  // R1
  no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni || !we_ni) |-> !bus_oe_o);
  // R2
  true_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && !busy_i) |-> bus_o == arr_data_i);
  // R3
  poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && busy_i && seen && !prog_start_i) |-> bus_o[POLL_BIT] == ~ref_poll);
  // R4
  tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && busy_i && $past(bus_oe_o) && $past(busy_i)) |-> $stable(bus_o[TOG_BIT]));
  // R5
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && busy_i) |-> (bus_o & ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT))) == '0);
endmodule

bind poll_status_rd poll_status_rd_chk #(
  .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
  .busy_i(busy_i), .prog_start_i(prog_start_i), .wr_data_i(wr_data_i),
  .arr_data_i(arr_data_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
);

// File: tb/poll_status_rd_bench.sv
`timescale 1ns/1ps
module poll_status_rd_bench;
  logic       clk_i = 0, rst_ni = 0;
  logic       ce_ni = 1, oe_ni = 1, we_ni = 1;
  logic       busy_i = 0, prog_start_i = 0;
  logic [7:0] wr_data_i = 0, arr_data_i = 0, bus_o;
  logic       bus_oe_o;
  int n_cmp = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  poll_status_rd u_poll_status_rd (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one read access; value sampled after a full cycle of the access
  task automatic rd(output logic [7:0] v, output logic oe);
    @(negedge clk_i); ce_ni = 0; oe_ni = 0; we_ni = 1;
    @(negedge clk_i); #1; v = bus_o; oe = bus_oe_o;
    @(negedge clk_i); ce_ni = 1; oe_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic start_prog(input logic [7:0] b);
    @(negedge clk_i); prog_start_i = 1; busy_i = 1; wr_data_i = b;
    @(negedge clk_i); prog_start_i = 0; wr_data_i = ~b;  // later changes must not matter
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    logic oe;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R9 oe after reset", {7'd0, bus_oe_o}, 8'd0);
    chk("R9 bus after reset", bus_o, 8'd0);
    rst_ni = 1;

    // R1: sweep all select combinations
    for (int c = 0; c < 8; c++) begin
      @(negedge clk_i);
      ce_ni = c[0]; oe_ni = c[1]; we_ni = c[2]; arr_data_i = 8'h5a ^ 8'(c);
      #1;
      chk("R1 oe", {7'd0, bus_oe_o}, {7'd0, (c == 4)});
      chk("R1 data", bus_o, (c == 4) ? (8'h5a ^ 8'(c)) : 8'h00);
    end
    @(negedge clk_i); ce_ni = 1; oe_ni = 1; we_ni = 1;

    // exhaustive over the programmed byte
    for (int b = 0; b < 256; b++) begin
      start_prog(8'(b));
      rd(v, oe);
      chk("R1 busy read oe", {7'd0, oe}, 8'd1);
      chk("R3 poll bit", {7'd0, v[7]}, {7'd0, ~b[7]});
      chk("R5 low bits", {2'd0, v[5:0]}, 8'd0);
      wr_data_i = 8'(b * 3 + 1);
      rd(v2, oe);
      chk("R6 poll bit after wr_data change", {7'd0, v2[7]}, {7'd0, ~b[7]});
      chk("R4 toggle alternates", {7'd0, v2[6]}, {7'd0, ~v[6]});
      if (b % 16 == 0) begin
        // R8: a select with write low is not a read
        @(negedge clk_i); ce_ni = 0; oe_ni = 0; we_ni = 0;
        #1; chk("R8 no drive", {7'd0, bus_oe_o}, 8'd0);
        @(negedge clk_i); ce_ni = 1; oe_ni = 1; we_ni = 1;
        @(negedge clk_i);
        rd(v, oe);
        chk("R8 toggle not advanced", {7'd0, v[6]}, {7'd0, ~v2[6]});
      end
      @(negedge clk_i); busy_i = 0; arr_data_i = 8'(b * 37 + 11);
      rd(v, oe);
      chk("R2 true data", v, 8'(b * 37 + 11));
    end

    // R4: bit 6 steady within a long access
    start_prog(8'h00);
    @(negedge clk_i); ce_ni = 0; oe_ni = 0;
    @(negedge clk_i); #1; v = bus_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); #1;
      chk("R4 toggle steady in access", {7'd0, bus_o[6]}, {7'd0, v[6]});
    end
    @(negedge clk_i); ce_ni = 1; oe_ni = 1;
    // R7: program start in the middle of an active read
    @(negedge clk_i); busy_i = 0; ce_ni = 0; oe_ni = 0;
    @(negedge clk_i); busy_i = 1; prog_start_i = 1; wr_data_i = 8'h80;
    #1; chk("R7 same-cycle poll bit", {7'd0, bus_o[7]}, 8'd0);
    @(negedge clk_i); prog_start_i = 0; wr_data_i = 8'h00;
    #1; chk("R7 poll bit held", {7'd0, bus_o[7]}, 8'd0);
    v = bus_o;
    @(negedge clk_i); ce_ni = 1; oe_ni = 1;
    @(negedge clk_i);
    rd(v2, oe);
    chk("R4 toggle after concurrent start", {7'd0, v2[6]}, {7'd0, ~v[6]});
    @(negedge clk_i); busy_i = 0;
    @(negedge clk_i); #1;
    chk("R1 idle bus zero", bus_o, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule